// File: doc/BRIEF.md
# I2C Configuration Register Bank Slave

This block is an I2C slave that holds eight 8-bit configuration registers and presents them to the surrounding logic as one 64-bit word. A bus master reaches the registers through a pointer. After addressing the slave for a write, the master sends a pointer byte. Data bytes that follow are written starting at that register. Alternatively, the master issues a repeated START and reads back from the same place. The pointer advances after every byte in either direction and wraps around inside the eight registers.

The slave answers to a 7-bit address. Its upper five bits are a fixed prefix and its two lowest bits come from strap inputs, so four copies can share one bus. SCL and SDA are brought into the system clock domain through a short synchronizer. The system clock is expected to run at least 16 times faster than SCL. The slave pulls SDA low only through an open-drain enable. Each register takes its new value at the moment the slave starts acknowledging that byte, and a one-cycle strobe marks which register changed.

Top module: `cfgbank_i2c_slave`

## Requirements
- R1: The slave acknowledges a START followed by the byte {1,0,1,1,0,strap_i[1],strap_i[0],rw}, sent MSB first. Any other address byte is not acknowledged, and the slave leaves SDA alone until the next START.
- R2: The all-zero general-call address byte 0x00 is never acknowledged and changes no register.
- R3: After an address with rw=0, the first byte sets the pointer from its low three bits. Each later byte is written to the pointed register, and then the pointer increases by one.
- R4: The pointer wraps from register 7 to register 0, so a ninth byte in one sequential write overwrites the first register written.
- R5: A data byte is committed at the SCL falling edge that ends its eighth bit, together with the start of the slave's ACK and before any STOP. In the following clock, byte_upd_o pulses one-hot with bit i set for register i.
- R6: A repeated START leaves the pointer unchanged. A read addressed right after a pointer byte returns the register that pointer selects.
- R7: During a read, bytes are shifted out MSB first, and the pointer advances after each byte. A master ACK continues with the next register. A master NACK ends the read, after which the slave keeps SDA released.
- R8: After reset all 64 configuration bits are zero. Every register reads back exactly the value last written to it.
- R9: A STOP or repeated START that arrives before the eighth bit of a data byte discards the partial byte. No register changes and no update strobe occurs.
- R10: The slave drives SDA low only during its own ACK bit and during zero bits of read data. It keeps SDA released while the master sends address or data bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad (wired-AND of all drivers) |
| strap_i | input | 2 | Low two bits of the slave address |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_word_o | output | 64 | Register i on bits [8i+7:8i] |
| byte_upd_o | output | 8 | One-cycle one-hot strobe naming the register just written |

## Verification
Several things happen on a single SCL falling edge after the eighth bit of a data byte: the register write, the pointer increment and the start of the slave's ACK. When the pointer sits at register 7, the wrap from 7 to 0 also lands on that same edge. The bench provokes this with a nine-byte sequential write that starts at register 6 and crosses the wrap. It judges the result in three ways. It sees the ACK as a low SDA sample. It checks that the register holds its new value before STOP is sent. It checks that each strobe names the register predicted by its own pointer model. STOP against an incomplete byte is a second collision, and the bench covers it by aborting bytes part-way through with STOP and with repeated START.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_ACK,
        PH_TX,
        PH_MACK
    } phase_e;

    typedef enum logic [1:0] {
        RX_DEV,
        RX_PTR,
        RX_DATA
    } rxkind_e;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned ADDR7_W = 7;

endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int unsigned TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_pipe;
        logic [SYNC_STAGES-1:0] sda_pipe;
        logic                   scl_last;
        logic                   sda_last;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d          = q;
        d.scl_pipe = {q.scl_pipe[TOP-1:0], scl_i};
        d.sda_pipe = {q.sda_pipe[TOP-1:0], sda_i};
        d.scl_last = q.scl_pipe[TOP];
        d.sda_last = q.sda_pipe[TOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    logic scl_now;
    assign scl_now    = q.scl_pipe[TOP];
    assign sda_o      = q.sda_pipe[TOP];
    assign scl_rise_o = scl_now & ~q.scl_last;
    assign scl_fall_o = ~scl_now & q.scl_last;
    assign start_o    = scl_now & q.scl_last & q.sda_last & ~sda_o;
    assign stop_o     = scl_now & q.scl_last & ~q.sda_last & sda_o;

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import cfgbank_pkg::*;
#(
    parameter int unsigned PTR_W      = 3,
    parameter logic [4:0]  DEV_PREFIX = 5'b10110
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_i,
    input  logic             scl_rise_i,
    input  logic             scl_fall_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [1:0]       strap_i,
    input  logic [7:0]       rd_data_i,
    output logic [PTR_W-1:0] rd_addr_o,
    output logic             we_o,
    output logic [PTR_W-1:0] wr_addr_o,
    output logic [7:0]       wr_data_o,
    output logic             sda_oe_o
);
    localparam logic [3:0] LAST_BIT = 4'd7;
    localparam logic [3:0] FULL_CNT = 4'd8;

    typedef struct packed {
        phase_e            ph;
        rxkind_e           kind;
        logic [3:0]        cnt;
        logic [7:0]        sh;
        logic [PTR_W-1:0]  ptr;
        logic              rd;
        logic              mack;
        logic              oe;
    } eng_t;

    eng_t q, d;
    logic [ADDR7_W-1:0] my_addr;
    assign my_addr = {DEV_PREFIX, strap_i};

    always_comb begin
        d         = q;
        we_o      = 1'b0;
        wr_addr_o = q.ptr;
        wr_data_o = q.sh;
        if (stop_i) begin
            d.ph  = PH_IDLE;
            d.oe  = 1'b0;
            d.cnt = '0;
        end else if (start_i) begin
            d.ph   = PH_RX;
            d.kind = RX_DEV;
            d.cnt  = '0;
            d.oe   = 1'b0;
        end else begin
            unique case (q.ph)
                PH_RX: begin
                    if (scl_rise_i && q.cnt != FULL_CNT) begin
                        d.sh  = {q.sh[6:0], sda_i};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall_i && q.cnt == FULL_CNT) begin
                        d.cnt = '0;
                        unique case (q.kind)
                            RX_DEV: begin
                                if (q.sh[7:1] == my_addr) begin
                                    d.ph   = PH_ACK;
                                    d.oe   = 1'b1;
                                    d.rd   = q.sh[0];
                                    d.kind = RX_PTR;
                                end else begin
                                    d.ph = PH_IDLE;
                                end
                            end
                            RX_PTR: begin
                                d.ptr  = q.sh[PTR_W-1:0];
                                d.ph   = PH_ACK;
                                d.oe   = 1'b1;
                                d.rd   = 1'b0;
                                d.kind = RX_DATA;
                            end
                            default: begin
                                we_o  = 1'b1;
                                d.ptr = q.ptr + PTR_W'(1);
                                d.ph  = PH_ACK;
                                d.oe  = 1'b1;
                                d.rd  = 1'b0;
                            end
                        endcase
                    end
                end
                PH_ACK: begin
                    if (scl_fall_i) begin
                        d.cnt = '0;
                        if (q.rd) begin
                            d.ph  = PH_TX;
                            d.sh  = rd_data_i;
                            d.ptr = q.ptr + PTR_W'(1);
                            d.oe  = ~rd_data_i[7];
                        end else begin
                            d.ph = PH_RX;
                            d.oe = 1'b0;
                        end
                    end
                end
                PH_TX: begin
                    if (scl_fall_i) begin
                        if (q.cnt == LAST_BIT) begin
                            d.ph = PH_MACK;
                            d.oe = 1'b0;
                        end else begin
                            d.sh  = {q.sh[6:0], 1'b0};
                            d.cnt = q.cnt + 4'd1;
                            d.oe  = ~q.sh[6];
                        end
                    end
                end
                PH_MACK: begin
                    if (scl_rise_i) begin
                        d.mack = ~sda_i;
                    end else if (scl_fall_i) begin
                        d.cnt = '0;
                        if (q.mack) begin
                            d.ph  = PH_TX;
                            d.sh  = rd_data_i;
                            d.ptr = q.ptr + PTR_W'(1);
                            d.oe  = ~rd_data_i[7];
                        end else begin
                            d.ph = PH_IDLE;
                        end
                    end
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.ph   <= PH_IDLE;
            q.kind <= RX_DEV;
        end else begin
            q <= d;
        end
    end

    assign rd_addr_o = q.ptr;
    assign sda_oe_o  = q.oe;

    assert_oe_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe_o |-> (q.ph == PH_ACK || q.ph == PH_TX));

    assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (!sda_oe_o && q.ph == PH_IDLE));

    assert_start_keeps_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !stop_i) |=> ($stable(q.ptr) && q.ph == PH_RX));

    assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (we_o && q.ptr == '1) |=> (q.ptr == '0));

    assert_ack_with_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |=> sda_oe_o);

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
    parameter int unsigned NREG  = 8,
    parameter int unsigned PTR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [PTR_W-1:0]  wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic [PTR_W-1:0]  rd_addr_i,
    output logic [7:0]        rd_data_o,
    output logic [NREG*8-1:0] cfg_o,
    output logic [NREG-1:0]   upd_o
);
    typedef struct packed {
        logic [NREG-1:0][7:0] regs;
        logic [NREG-1:0]      upd;
    } bank_t;

    bank_t q, d;

    always_comb begin
        d     = q;
        d.upd = '0;
        for (int i = 0; i < NREG; i++) begin
            if (we_i && wr_addr_i == PTR_W'(i)) begin
                d.regs[i] = wr_data_i;
                d.upd[i]  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_flat
            assign cfg_o[g*8 +: 8] = q.regs[g];
        end
    endgenerate

    assign rd_data_o = q.regs[rd_addr_i];
    assign upd_o     = q.upd;

    assert_upd_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(upd_o));

    assert_upd_follows_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|upd_o) |-> $past(we_i));

    assert_hold_without_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(cfg_o));

endmodule

// File: rtl/cfgbank_i2c_slave.sv
module cfgbank_i2c_slave #(
    parameter int unsigned NUM_REGS    = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [4:0]  DEV_PREFIX  = 5'b10110
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    input  logic [1:0]            strap_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] cfg_word_o,
    output logic [NUM_REGS-1:0]   byte_upd_o
);
    localparam int unsigned PTR_W = $clog2(NUM_REGS);

    logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic             we;
    logic [PTR_W-1:0] wr_addr, rd_addr;
    logic [7:0]       wr_data, rd_data;

    i2c_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    i2c_slave_fsm #(.PTR_W(PTR_W), .DEV_PREFIX(DEV_PREFIX)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_i      (sda_s),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_det),
        .stop_i     (stop_det),
        .strap_i    (strap_i),
        .rd_data_i  (rd_data),
        .rd_addr_o  (rd_addr),
        .we_o       (we),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .sda_oe_o   (sda_oe_o)
    );

    cfg_reg_bank #(.NREG(NUM_REGS), .PTR_W(PTR_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (we),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .cfg_o     (cfg_word_o),
        .upd_o     (byte_upd_o)
    );

endmodule

// File: tb/sim_cfgbank_i2c_slave.sv
module sim_cfgbank_i2c_slave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic [1:0]  strap = 2'b10;
    logic        sda_oe;
    logic [63:0] cfg;
    logic [7:0]  upd;
    wire         sda_bus = m_sda & ~sda_oe;

    always #5 clk = ~clk;

    cfgbank_i2c_slave u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_bus),
        .strap_i    (strap),
        .sda_oe_o   (sda_oe),
        .cfg_word_o (cfg),
        .byte_upd_o (upd)
    );

    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;
    logic [7:0] shadow [8];
    logic [10:0] expq [$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] packed_shadow();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[i*8 +: 8] = shadow[i];
        return v;
    endfunction

    // scoreboard monitor: every strobe must match the next expected write
    always @(negedge clk) begin
        if (rst_n && upd != 8'h00) begin
            if (expq.size() == 0) begin
                check(1'b0, "R9", "strobe with no write expected", {56'h0, upd}, 64'h0);
            end else begin
                logic [10:0] it;
                it = expq.pop_front();
                check(upd == (8'h01 << it[10:8]), "R5", "strobe position",
                      {56'h0, upd}, {56'h0, 8'h01 << it[10:8]});
                check(cfg[it[10:8]*8 +: 8] == it[7:0], "R3", "committed value",
                      {56'h0, cfg[it[10:8]*8 +: 8]}, {56'h0, it[7:0]});
            end
        end
    end

    task automatic hp();
        repeat (10) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; hp();
        m_scl = 1'b1; hp();
        m_sda = 1'b0; hp();
        m_scl = 1'b0; hp();
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; hp();
        m_scl = 1'b1; hp();
        m_sda = 1'b1; hp();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; hp();
        m_scl = 1'b1; hp();
        check(sda_oe == 1'b0, "R10", "slave drove SDA during master bit", {63'h0, sda_oe}, 64'h0);
        hp();
        m_scl = 1'b0; hp();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; hp();
        m_scl = 1'b1; hp();
        ack = ~sda_bus;
        hp();
        m_scl = 1'b0; hp();
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            m_sda = 1'b1; hp();
            m_scl = 1'b1; hp();
            b = {b[6:0], sda_bus};
            hp();
            m_scl = 1'b0;
        end
        hp();
        m_sda = mack ? 1'b0 : 1'b1; hp();
        m_scl = 1'b1; hp(); hp();
        m_scl = 1'b0; hp();
        m_sda = 1'b1;
    endtask

    function automatic logic [7:0] dev(input logic rw);
        return {5'b10110, strap, rw};
    endfunction

    task automatic put_data(input int idx, input logic [7:0] v);
        bit ack;
        expq.push_back({idx[2:0], v});
        shadow[idx] = v;
        send_byte(v, ack);
        check(ack, "R5", "data byte acknowledged", {63'h0, ack}, 64'h1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run hung actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit         ack;
        logic [7:0] b;
        for (int i = 0; i < 8; i++) shadow[i] = 8'h00;

        // reset state, R8 and R10
        repeat (4) @(negedge clk);
        check(cfg == 64'h0, "R8", "config word in reset", cfg, 64'h0);
        check(sda_oe == 1'b0, "R10", "SDA released in reset", {63'h0, sda_oe}, 64'h0);
        check(upd == 8'h0, "R5", "no strobe in reset", {56'h0, upd}, 64'h0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: address with wrong strap bits is ignored
        i2c_start();
        send_byte({5'b10110, ~strap, 1'b0}, ack);
        check(!ack, "R1", "foreign address acked", {63'h0, ack}, 64'h0);
        send_byte(8'h02, ack);
        check(!ack, "R1", "byte after foreign address acked", {63'h0, ack}, 64'h0);
        i2c_stop();
        check(cfg == 64'h0, "R1", "foreign transfer changed config", cfg, 64'h0);

        // R2: general call ignored
        i2c_start();
        send_byte(8'h00, ack);
        check(!ack, "R2", "general call acked", {63'h0, ack}, 64'h0);
        send_byte(8'h03, ack);
        i2c_stop();
        check(cfg == 64'h0, "R2", "general call changed config", cfg, 64'h0);

        // R3/R5: random write, committed before STOP
        i2c_start();
        send_byte(dev(1'b0), ack);
        check(ack, "R1", "own address acked", {63'h0, ack}, 64'h1);
        send_byte(8'hF3, ack);
        check(ack, "R3", "pointer byte acked", {63'h0, ack}, 64'h1);
        put_data(3, 8'hA5);
        check(cfg[31:24] == 8'hA5, "R5", "register updated before STOP", {56'h0, cfg[31:24]}, 64'hA5);
        i2c_stop();

        // R4: sequential write of nine bytes from register 6 wraps
        i2c_start();
        send_byte(dev(1'b0), ack);
        send_byte(8'h06, ack);
        for (int i = 0; i < 9; i++) put_data((6 + i) % 8, 8'h10 + 8'(i));
        i2c_stop();
        check(cfg[55:48] == 8'h18, "R4", "ninth byte overwrote first register", {56'h0, cfg[55:48]}, 64'h18);
        check(cfg == packed_shadow(), "R4", "config after wrapped write", cfg, packed_shadow());

        // R6: random read via repeated START
        i2c_start();
        send_byte(dev(1'b0), ack);
        send_byte(8'h02, ack);
        i2c_start();
        send_byte(dev(1'b1), ack);
        check(ack, "R6", "read address acked", {63'h0, ack}, 64'h1);
        recv_byte(1'b0, b);
        check(b == shadow[2], "R6", "random read value", {56'h0, b}, {56'h0, shadow[2]});
        check(sda_oe == 1'b0, "R7", "SDA released after NACK", {63'h0, sda_oe}, 64'h0);
        i2c_stop();

        // R7/R8: sequential read from register 5 over ten bytes
        i2c_start();
        send_byte(dev(1'b0), ack);
        send_byte(8'h05, ack);
        i2c_start();
        send_byte(dev(1'b1), ack);
        for (int i = 0; i < 10; i++) begin
            recv_byte(i != 9, b);
            check(b == shadow[(5 + i) % 8], "R7", "sequential read value",
                  {56'h0, b}, {56'h0, shadow[(5 + i) % 8]});
        end
        check(sda_oe == 1'b0, "R7", "SDA released after final NACK", {63'h0, sda_oe}, 64'h0);
        i2c_stop();

        // R9: partial byte cut by STOP
        i2c_start();
        send_byte(dev(1'b0), ack);
        send_byte(8'h00, ack);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        i2c_stop();
        check(cfg == packed_shadow(), "R9", "partial byte before STOP changed config", cfg, packed_shadow());

        // R9/R6: partial byte cut by repeated START, pointer kept
        i2c_start();
        send_byte(dev(1'b0), ack);
        send_byte(8'h01, ack);
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        i2c_start();
        send_byte(dev(1'b1), ack);
        recv_byte(1'b0, b);
        check(b == shadow[1], "R9", "read after aborted byte", {56'h0, b}, {56'h0, shadow[1]});
        i2c_stop();
        check(cfg == packed_shadow(), "R9", "aborted byte changed config", cfg, packed_shadow());

        // R1: new strap value moves the address
        strap = 2'b01;
        repeat (10) @(negedge clk);
        i2c_start();
        send_byte(dev(1'b0), ack);
        check(ack, "R1", "address with new strap acked", {63'h0, ack}, 64'h1);
        send_byte(8'h07, ack);
        put_data(7, 8'h3C);
        put_data(0, 8'hFF);
        i2c_stop();

        // R8: full readback after mixed writes
        i2c_start();
        send_byte(dev(1'b0), ack);
        send_byte(8'h00, ack);
        i2c_start();
        send_byte(dev(1'b1), ack);
        for (int i = 0; i < 8; i++) begin
            recv_byte(i != 7, b);
            check(b == shadow[i], "R8", "readback", {56'h0, b}, {56'h0, shadow[i]});
        end
        i2c_stop();
        check(cfg == packed_shadow(), "R8", "final config word", cfg, packed_shadow());
        check(expq.size() == 0, "R5", "expected writes left unseen", 64'(expq.size()), 64'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule